// File: doc/BRIEF.md
# Logic Analyzer Trigger Unit

This block decides when an embedded logic analyzer should start or mark a capture. It watches a stream of samples, each tagged with a valid strobe, and raises a single-cycle `hit` output when a programmable condition holds. The block contains three kinds of detector. A masked-compare detector matches selected bits against a value. A window detector checks that the sample lies between two bounds. A transition detector looks at each bit for rising, falling or either-direction changes.

The single-bit outputs of all detectors are concatenated into an index. That index selects one bit of a lookup table that the host loads one entry at a time. The selected bit becomes the trigger, so any Boolean function of the detector outputs can be expressed. Detector settings are loaded through one shared write port that carries a kind, an instance index and a field selector. The table has its own address, bit and write-strobe port. Capture storage and the host link sit outside this block.

Top module: `la_trigger_unit`

## Requirements
- R1: `hit` is registered: in the cycle after a sample with `smp_valid`=1, `hit` equals the lookup-table bit addressed by the detector vector of that sample; after a cycle with `smp_valid`=0, `hit` is 0.
- R2: Masked-compare detector i fires when `(smp_data & mask) == (value & mask)`; with a mask of zero it fires on every sample.
- R3: Window detector j fires when `low <= smp_data <= high`, compared unsigned with both bounds included.
- R4: Transition detector k compares the sample with the previous valid sample. It fires if any bit rose (0 to 1) under its rise mask, fell (1 to 0) under its fall mask, or changed under its any-change mask. It never fires on the first valid sample after reset. Samples with `smp_valid`=0 do not replace the stored previous sample.
- R5: The detector vector places masked-compare detector i at bit i, window detector j at bit N_TERM+j, and transition detector k at bit N_TERM+N_RANGE+k.
- R6: A table write (`tbl_we`=1) stores `tbl_bit` at entry `tbl_addr` at the clock edge. Samples in later cycles use the new entry; a sample presented in the same cycle as the write still uses the old entry.
- R7: After reset every table entry, value, mask and bound is zero, and `hit` is 0.
- R8: A settings write (`cfg_we`=1) loads `cfg_wdata` into instance `cfg_idx` of the detector kind `cfg_kind`, which is 0 for masked-compare, 1 for window and 2 for transition. `cfg_field` selects the register: for masked-compare 0 is value and 1 is mask; for window 0 is low and 1 is high; for transition 0 is rise, 1 is fall and 2 is any-change. The new setting applies from the next cycle's sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample word |
| cfg_we | input | 1 | Detector setting write strobe |
| cfg_kind | input | 2 | Detector kind selector |
| cfg_idx | input | IDX_W | Instance index within the kind |
| cfg_field | input | 2 | Register selector within the instance |
| cfg_wdata | input | DATA_W | Setting value |
| tbl_we | input | 1 | Lookup-table write strobe |
| tbl_addr | input | N_TERM+N_RANGE+N_EDGE | Table entry index |
| tbl_bit | input | 1 | Table entry value |
| hit | output | 1 | Trigger, one cycle per qualifying sample |

## Verification
The bench builds the block with DATA_W=8, two masked-compare detectors, one window detector and one transition detector. This gives a 4-bit detector vector and a 16-entry table. At this size the bench can rewrite the entire table between phases, so each detector can be isolated, and each detector's boundaries can be reached with byte values. This covers the window endpoints and the values just outside them, partial masks, and bit transitions both masked and unmasked. It also covers same-cycle collisions of table or setting writes with a valid sample, and invalid samples placed between two valid ones.

// File: rtl/la_trig_pkg.sv
// Shared encodings for the trigger unit: detector kinds and field codes.
// Assumes the kind selector is two bits wide.
package la_trig_pkg;
    typedef enum logic [1:0] {
        KIND_TERM  = 2'd0,
        KIND_RANGE = 2'd1,
        KIND_EDGE  = 2'd2
    } det_kind_e;

    localparam logic [1:0] FLD_TERM_VAL  = 2'd0;
    localparam logic [1:0] FLD_TERM_MASK = 2'd1;
    localparam logic [1:0] FLD_RNG_LO    = 2'd0;
    localparam logic [1:0] FLD_RNG_HI    = 2'd1;
    localparam logic [1:0] FLD_EDG_RISE  = 2'd0;
    localparam logic [1:0] FLD_EDG_FALL  = 2'd1;
    localparam logic [1:0] FLD_EDG_ANY   = 2'd2;
endpackage

// File: rtl/la_term_det.sv
// Masked-compare detector: holds a value and a mask and fires when the
// masked sample bits equal the masked value. Assumes wr_en is already
// qualified for this instance.
module la_term_det #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] smp_data,
    output logic              match
);
    import la_trig_pkg::*;

    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] mask_q;

    // Load value or mask from the settings port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_field == FLD_TERM_VAL)  val_q  <= wr_data;
            if (wr_field == FLD_TERM_MASK) mask_q <= wr_data;
        end
    end

    // Compare only the bits the mask selects.
    always_comb begin
        match = ((smp_data ^ val_q) & mask_q) == '0;
    end
endmodule

// File: rtl/la_range_det.sv
// Window detector: fires when the sample lies between the low and high
// bounds, unsigned and inclusive. Assumes wr_en is qualified per instance.
module la_range_det #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] smp_data,
    output logic              match
);
    import la_trig_pkg::*;

    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    // Load a bound from the settings port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            if (wr_field == FLD_RNG_LO) lo_q <= wr_data;
            if (wr_field == FLD_RNG_HI) hi_q <= wr_data;
        end
    end

    // Inclusive unsigned window test.
    always_comb begin
        match = (smp_data >= lo_q) && (smp_data <= hi_q);
    end
endmodule

// File: rtl/la_edge_det.sv
// Transition detector: compares the sample with the previous valid sample
// under rise, fall and any-change masks. Assumes prev/have_prev come from
// a register that only updates on valid samples.
module la_edge_det #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] prev_data,
    input  logic              have_prev,
    output logic              match
);
    import la_trig_pkg::*;

    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] fall_q;
    logic [DATA_W-1:0] any_q;
    logic [DATA_W-1:0] rose;
    logic [DATA_W-1:0] fell;

    // Load one of the three masks from the settings port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            any_q  <= '0;
        end else if (wr_en) begin
            if (wr_field == FLD_EDG_RISE) rise_q <= wr_data;
            if (wr_field == FLD_EDG_FALL) fall_q <= wr_data;
            if (wr_field == FLD_EDG_ANY)  any_q  <= wr_data;
        end
    end

    // Per-bit transitions gated by their masks.
    always_comb begin
        rose  = smp_data & ~prev_data;
        fell  = ~smp_data & prev_data;
        match = have_prev &&
                (|((rose & rise_q) | (fell & fall_q) | ((rose | fell) & any_q)));
    end
endmodule

// File: rtl/la_comb_table.sv
// Combiner lookup table: one bit per detector-vector value, written one
// entry at a time, read combinationally. Assumes a small detector count.
module la_comb_table #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] tbl_q;

    // Store a single entry; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     tbl_q <= '0;
        else if (wr_en) tbl_q[wr_addr] <= wr_bit;
    end

    // Select the entry addressed by the detector vector.
    always_comb begin
        rd_bit = tbl_q[rd_addr];
    end
endmodule

// File: rtl/la_trigger_unit.sv
// Trigger unit top: instantiates the detector banks, keeps the previous
// valid sample, looks up the combiner table and registers the hit.
// Assumes N_TERM, N_RANGE, N_EDGE >= 1 and 2**IDX_W >= each count.
module la_trigger_unit #(
    parameter int DATA_W  = 16,
    parameter int N_TERM  = 2,
    parameter int N_RANGE = 1,
    parameter int N_EDGE  = 1,
    parameter int IDX_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             smp_valid,
    input  logic [DATA_W-1:0]                smp_data,
    input  logic                             cfg_we,
    input  logic [1:0]                       cfg_kind,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [1:0]                       cfg_field,
    input  logic [DATA_W-1:0]                cfg_wdata,
    input  logic                             tbl_we,
    input  logic [N_TERM+N_RANGE+N_EDGE-1:0] tbl_addr,
    input  logic                             tbl_bit,
    output logic                             hit
);
    import la_trig_pkg::*;

    localparam int N_DET      = N_TERM + N_RANGE + N_EDGE;
    localparam int RANGE_BASE = N_TERM;
    localparam int EDGE_BASE  = N_TERM + N_RANGE;

    logic [N_DET-1:0]  det_vec;
    logic [DATA_W-1:0] prev_q;
    logic              have_prev_q;
    logic              tbl_out;

    // Remember the most recent valid sample for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (smp_valid) begin
            prev_q      <= smp_data;
            have_prev_q <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < N_TERM; i++) begin : g_term
            logic we_i;
            assign we_i = cfg_we && (cfg_kind == KIND_TERM) && (cfg_idx == IDX_W'(i));
            la_term_det #(.DATA_W(DATA_W)) u_term (
                .clk(clk), .rst_n(rst_n), .wr_en(we_i), .wr_field(cfg_field),
                .wr_data(cfg_wdata), .smp_data(smp_data), .match(det_vec[i])
            );
        end
        for (genvar j = 0; j < N_RANGE; j++) begin : g_range
            logic we_j;
            assign we_j = cfg_we && (cfg_kind == KIND_RANGE) && (cfg_idx == IDX_W'(j));
            la_range_det #(.DATA_W(DATA_W)) u_range (
                .clk(clk), .rst_n(rst_n), .wr_en(we_j), .wr_field(cfg_field),
                .wr_data(cfg_wdata), .smp_data(smp_data),
                .match(det_vec[RANGE_BASE+j])
            );
        end
        for (genvar k = 0; k < N_EDGE; k++) begin : g_edge
            logic we_k;
            assign we_k = cfg_we && (cfg_kind == KIND_EDGE) && (cfg_idx == IDX_W'(k));
            la_edge_det #(.DATA_W(DATA_W)) u_edge (
                .clk(clk), .rst_n(rst_n), .wr_en(we_k), .wr_field(cfg_field),
                .wr_data(cfg_wdata), .smp_data(smp_data), .prev_data(prev_q),
                .have_prev(have_prev_q), .match(det_vec[EDGE_BASE+k])
            );
        end
    endgenerate

    la_comb_table #(.AW(N_DET)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
        .wr_bit(tbl_bit), .rd_addr(det_vec), .rd_bit(tbl_out)
    );

    // Register the trigger, qualified by the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= smp_valid && tbl_out;
    end
endmodule

// File: rtl/la_trigger_unit_chk.sv
// Property checker for the trigger unit; keeps its own shadow of the
// table from the write port and compares the registered hit against it.
module la_trigger_unit_chk #(
    parameter int N_DET     = 4,
    parameter int EDGE_BASE = 3,
    parameter int N_EDGE    = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic             tbl_we,
    input logic [N_DET-1:0] tbl_addr,
    input logic             tbl_bit,
    input logic [N_DET-1:0] det_vec,
    input logic             hit
);
    logic [(1<<N_DET)-1:0] shadow_q;
    logic                  any_set_q;
    logic                  seen_valid_q;

    // Track table contents, whether any entry was set, and first valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q     <= '0;
            any_set_q    <= 1'b0;
            seen_valid_q <= 1'b0;
        end else begin
            if (tbl_we) shadow_q[tbl_addr] <= tbl_bit;
            if (tbl_we && tbl_bit) any_set_q <= 1'b1;
            if (smp_valid) seen_valid_q <= 1'b1;
        end
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(smp_valid)); // R1
    AST_HIT_MATCHES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit == $past(smp_valid && shadow_q[det_vec])); // R6
    AST_CLEAR_TABLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(any_set_q)); // R7
    AST_FIRST_SAMPLE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_valid_q |-> (det_vec[EDGE_BASE +: N_EDGE] == '0)); // R4
endmodule

bind la_trigger_unit la_trigger_unit_chk #(
    .N_DET(N_TERM + N_RANGE + N_EDGE),
    .EDGE_BASE(N_TERM + N_RANGE),
    .N_EDGE(N_EDGE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_bit(tbl_bit), .det_vec(det_vec), .hit(hit)
);

// File: tb/tb_la_trigger_unit.sv
module tb_la_trigger_unit;
    localparam int DW = 8;
    localparam int NT = 2;
    localparam int NR = 1;
    localparam int NE = 1;
    localparam int ND = NT + NR + NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [1:0]    cfg_idx = '0;
    logic [1:0]    cfg_field = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          tbl_we = 1'b0;
    logic [ND-1:0] tbl_addr = '0;
    logic          tbl_bit = 1'b0;
    logic          hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    la_trigger_unit #(.DATA_W(DW), .N_TERM(NT), .N_RANGE(NR), .N_EDGE(NE), .IDX_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit),
        .hit(hit)
    );

    always #10 clk = ~clk;

    // Reference state built from the requirements.
    logic [DW-1:0] m_tval [NT];
    logic [DW-1:0] m_tmask[NT];
    logic [DW-1:0] m_lo   [NR];
    logic [DW-1:0] m_hi   [NR];
    logic [DW-1:0] m_rise [NE];
    logic [DW-1:0] m_fall [NE];
    logic [DW-1:0] m_any  [NE];
    logic [(1<<ND)-1:0] m_tbl;
    logic [DW-1:0] m_prev;
    bit            m_have;

    typedef struct { bit exp; string tag; } item_t;
    item_t sbq[$];

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin m_tval[i] = '0; m_tmask[i] = '0; end
        for (int j = 0; j < NR; j++) begin m_lo[j] = '0; m_hi[j] = '0; end
        for (int k = 0; k < NE; k++) begin m_rise[k] = '0; m_fall[k] = '0; m_any[k] = '0; end
        m_tbl = '0; m_prev = '0; m_have = 0;
    endtask

    function automatic logic [ND-1:0] model_vec(logic [DW-1:0] d);
        logic [ND-1:0] v;
        logic [DW-1:0] r, f;
        for (int i = 0; i < NT; i++) v[i] = ((d & m_tmask[i]) == (m_tval[i] & m_tmask[i])); // R2, R5
        for (int j = 0; j < NR; j++) v[NT+j] = (d >= m_lo[j]) && (d <= m_hi[j]);          // R3
        r = d & ~m_prev;
        f = ~d & m_prev;
        for (int k = 0; k < NE; k++)
            v[NT+NR+k] = m_have && (|((r & m_rise[k]) | (f & m_fall[k]) | ((r | f) & m_any[k]))); // R4
        return v;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected hit.
    task automatic step(input bit v, input logic [DW-1:0] d, input string tag,
                        input bit cw = 0, input logic [1:0] ck = 0, input logic [1:0] ci = 0,
                        input logic [1:0] cf = 0, input logic [DW-1:0] cd = 0,
                        input bit tw = 0, input logic [ND-1:0] ta = 0, input bit tb = 0);
        item_t it;
        @(negedge clk);
        smp_valid = v; smp_data = d;
        cfg_we = cw; cfg_kind = ck; cfg_idx = ci; cfg_field = cf; cfg_wdata = cd;
        tbl_we = tw; tbl_addr = ta; tbl_bit = tb;
        it.exp = v && m_tbl[model_vec(d)];
        it.tag = tag;
        sbq.push_back(it);
        if (v) begin m_prev = d; m_have = 1; end
        if (tw) m_tbl[ta] = tb;
        if (cw) begin
            case (ck)
                2'd0: if (cf == 0) m_tval[ci] = cd; else if (cf == 1) m_tmask[ci] = cd;
                2'd1: if (cf == 0) m_lo[ci] = cd; else if (cf == 1) m_hi[ci] = cd;
                2'd2: if (cf == 0) m_rise[ci] = cd; else if (cf == 1) m_fall[ci] = cd;
                      else if (cf == 2) m_any[ci] = cd;
                default: ;
            endcase
        end
    endtask

    task automatic cfg(input logic [1:0] k, input logic [1:0] i, input logic [1:0] f,
                       input logic [DW-1:0] d);
        step(0, 0, "R8", 1, k, i, f, d);
    endtask

    // Load the whole table from a selector: 0 term0, 1 range, 2 edge, 3 term1 and not term0.
    task automatic load_table(input int sel);
        for (int a = 0; a < (1 << ND); a++) begin
            bit b;
            case (sel)
                0: b = a[0];
                1: b = a[2];
                2: b = a[3];
                default: b = a[1] && !a[0];
            endcase
            step(0, 0, "R6", 0, 0, 0, 0, 0, 1, ND'(a), b);
        end
    endtask

    // Monitor: compare the registered hit after each clock edge.
    always @(posedge clk) begin
        #3;
        if (rst_n && sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (hit !== it.exp) begin
                errors++;
                $display("FAIL %s hit actual=%0b expected=%0b", it.tag, hit, it.exp);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (hit !== 1'b0) begin errors++; $display("FAIL R7 reset hit actual=%0b expected=0", hit); end
        @(negedge clk); rst_n = 1'b1;

        // R7: cleared table gives no hit even though masked-compare matches everything.
        step(1, 8'h00, "R7"); step(1, 8'h5A, "R7"); step(1, 8'hFF, "R7");

        // R8: program detectors.
        cfg(2'd0, 2'd0, 2'd0, 8'hA5); cfg(2'd0, 2'd0, 2'd1, 8'hF0);
        cfg(2'd0, 2'd1, 2'd0, 8'h00); cfg(2'd0, 2'd1, 2'd1, 8'hFF);
        cfg(2'd1, 2'd0, 2'd0, 8'h10); cfg(2'd1, 2'd0, 2'd1, 8'h20);
        cfg(2'd2, 2'd0, 2'd0, 8'h01); cfg(2'd2, 2'd0, 2'd1, 8'h02);
        cfg(2'd2, 2'd0, 2'd2, 8'h80);

        // R2: masked compare only.
        load_table(0);
        step(1, 8'hA0, "R2"); step(1, 8'hAF, "R2"); step(1, 8'hB5, "R2");
        step(1, 8'h5A, "R2"); step(0, 8'hA5, "R1"); step(1, 8'hA5, "R1");

        // R3: window endpoints.
        load_table(1);
        step(1, 8'h0F, "R3"); step(1, 8'h10, "R3"); step(1, 8'h15, "R3");
        step(1, 8'h20, "R3"); step(1, 8'h21, "R3"); step(1, 8'hFF, "R3");

        // R4: transitions.
        load_table(2);
        step(1, 8'h00, "R4"); step(1, 8'h01, "R4"); step(1, 8'h01, "R4");
        step(1, 8'h00, "R4"); step(1, 8'h02, "R4"); step(1, 8'h00, "R4");
        step(1, 8'h80, "R4"); step(1, 8'h00, "R4"); step(1, 8'h04, "R4");
        step(1, 8'h00, "R4"); step(0, 8'h01, "R4"); step(1, 8'h00, "R4");

        // R5: bit order, term1 set with term0 clear.
        load_table(3);
        step(1, 8'h00, "R5"); step(1, 8'hA5, "R5"); step(1, 8'h01, "R5");

        // R6: table write colliding with a valid sample uses the old entry.
        step(1, 8'h15, "R6", 0, 0, 0, 0, 0, 1, 4'b0100, 1'b1);
        step(1, 8'h15, "R6");

        // R8: setting write colliding with a sample applies from the next one.
        step(1, 8'h30, "R8", 1, 2'd1, 2'd0, 2'd1, 8'h40);
        step(1, 8'h30, "R8");

        repeat (3) step(0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule